// File: doc/BRIEF.md
# CRT Controller Indexed Register Bank

This block is the host-facing register bank of a raster display timing controller. Software writes a register number to an index port and then writes a byte to a data port. The byte lands in whichever of the 25 registers (numbers 0x00 through 0x18) is currently selected. The index port reads back the last number written to it. A write to any register number above 0x18 is dropped and leaves no trace.

The bank turns the raw register bytes into the configuration values that a separate timing core uses. Several vertical parameters are 10 bits wide. Their low eight bits sit in their own registers. Their two upper bits are spread across an overflow register (0x07) and the scan-line register (0x09), and the bank joins these pieces together. A protect bit locks the horizontal and overflow registers against writes. One overflow bit stays writable even while the lock is on.

The bank also holds the vertical retrace interrupt. A rising edge on the retrace pulse input marks an interrupt as pending. Software clears it, or masks it, through register 0x11.

Top module: `vga_crtc_regbank`

## Requirements
- R1: After an index port write, `idx_rdata` returns all eight bits of the written value from the next cycle on. This holds for values above 0x18 too.
- R2: While bit 7 of register 0x11 is 1, data writes to registers 0x00 to 0x06 are ignored. Data writes to register 0x07 are also ignored, except for its bit 4.
- R3: Bit 4 of register 0x07 takes the written value even while protection is on. That bit is bit 8 of `line_cmp`.
- R4: `vtotal` = {0x07[5], 0x07[0], reg 0x06}. `vdisp_end` = {0x07[6], 0x07[1], reg 0x12}. `vret_start` = {0x07[7], 0x07[2], reg 0x10}.
- R5: `vblank_start` = {0x09[5], 0x07[3], reg 0x15}. `line_cmp` = {0x09[6], 0x07[4], reg 0x18}.
- R6: `disp_start` = {reg 0x0C, reg 0x0D} and `cur_addr` = {reg 0x0E, reg 0x0F}. Writing one byte leaves the other byte unchanged.
- R7: `cur_off` = 0x0A[5] and `cur_start` = 0x0A[4:0]. `cur_end` = 0x0B[4:0] and `cur_skew` = 0x0B[6:5], a delay of 0 to 3 character clocks.
- R8: A 0-to-1 transition of `vret` sets the pending flag. A level held high does not set it again. A data write to 0x11 with bit 4 = 0 clears the flag. If a rising edge and such a clearing write happen in the same cycle, the flag ends up set.
- R9: `irq` = pending AND NOT 0x11[5]. Masking the interrupt does not clear the pending flag.
- R10: A data write while the index is above 0x18 changes no register and no output.
- R11: After reset, every register, the index and the pending flag are 0, so `irq` is 0.
- R12: `max_scan` = 0x09[4:0] and `dbl_scan` = 0x09[7]. `preset_row` = 0x08[4:0] and `byte_pan` = 0x08[6:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Register number to select |
| idx_rdata | output | 8 | Index readback |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Byte for the selected register |
| vret | input | 1 | Vertical retrace pulse from the timing core |
| irq | output | 1 | Vertical retrace interrupt |
| htotal | output | 8 | Register 0x00 |
| hdisp_end | output | 8 | Register 0x01 |
| hret_start | output | 8 | Register 0x04 |
| vtotal | output | 10 | Assembled vertical total |
| vdisp_end | output | 10 | Assembled vertical display end |
| vret_start | output | 10 | Assembled vertical retrace start |
| vblank_start | output | 10 | Assembled vertical blank start |
| line_cmp | output | 10 | Assembled line compare |
| vret_end | output | 4 | Register 0x11 bits 3:0 |
| max_scan | output | 5 | Scan lines per row minus one |
| dbl_scan | output | 1 | Scan doubling enable |
| preset_row | output | 5 | Preset row scan |
| byte_pan | output | 2 | Byte panning |
| cur_start | output | 5 | First cursor scan line |
| cur_off | output | 1 | Cursor disable |
| cur_end | output | 5 | Last cursor scan line |
| cur_skew | output | 2 | Cursor delay in character clocks |
| disp_start | output | 16 | Display start address |
| cur_addr | output | 16 | Cursor address |
| row_offset | output | 8 | Register 0x13 |

## Verification
The bench writes overflow patterns whose bits alternate, so that a design that swaps the bit-8 and bit-9 sources, or mixes up which low-byte register goes with which parameter, gives a wrong 10-bit value. With protection on, it writes both register 0x00 and register 0x07. A design that blocks bit 4 of 0x07 leaves line compare stale. A design that lets the rest of 0x07 through changes vertical total. On the interrupt side, the bench clears the flag while the retrace level is still held high, which catches a design that triggers on the level instead of the edge. It also sets and clears the flag in the same cycle, which catches the wrong priority, and it masks the interrupt and then unmasks it, which catches a design where the mask clears the pending flag. Writes to register numbers above 0x18 are checked against every output group, so a design that wraps the index onto a real register is caught.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
    localparam int IDX_HTOT   = 8'h00;
    localparam int IDX_HDISP  = 8'h01;
    localparam int IDX_HRET   = 8'h04;
    localparam int IDX_VTOT   = 8'h06;
    localparam int IDX_OVF    = 8'h07;
    localparam int IDX_PRESET = 8'h08;
    localparam int IDX_MSCAN  = 8'h09;
    localparam int IDX_CSTART = 8'h0A;
    localparam int IDX_CEND   = 8'h0B;
    localparam int IDX_SADDR_H = 8'h0C;
    localparam int IDX_SADDR_L = 8'h0D;
    localparam int IDX_CADDR_H = 8'h0E;
    localparam int IDX_CADDR_L = 8'h0F;
    localparam int IDX_VRSTART = 8'h10;
    localparam int IDX_VRCTL   = 8'h11;
    localparam int IDX_VDEND   = 8'h12;
    localparam int IDX_ROWOFS  = 8'h13;
    localparam int IDX_VBSTART = 8'h15;
    localparam int IDX_LCMP    = 8'h18;

    // bit positions that other logic decodes
    localparam int PROT_BIT    = 7;  // reg 0x11
    localparam int VI_OFF_BIT  = 5;  // reg 0x11
    localparam int VI_KEEP_BIT = 4;  // reg 0x11
    localparam int LCMP8_BIT   = 4;  // reg 0x07
    localparam int PROT_LIMIT  = 8;  // regs below this number are lockable

    typedef struct packed {
        logic pending;
        logic vret_prev;
    } vint_state_t;
endpackage

// File: rtl/crtc_index_port.sv
module crtc_index_port #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wdata_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (we_i) idx_d = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx_o = idx_q;

    assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (idx_q == $past(wdata_i)));
endmodule

// File: rtl/crtc_reg_file.sv
module crtc_reg_file
    import crtc_pkg::*;
#(
    parameter int NUM_REGS = 25,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [IDX_W-1:0]                 wr_idx_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
    localparam int SEL_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      prot;
    logic      in_range;
    logic      locked;

    assign prot     = st_q.regs[IDX_VRCTL][PROT_BIT];
    assign in_range = (wr_idx_i < IDX_W'(NUM_REGS));
    assign locked   = prot && (wr_idx_i < IDX_W'(PROT_LIMIT));

    always_comb begin
        st_d = st_q;
        if (wr_en_i && in_range) begin
            if (locked) begin
                if (wr_idx_i == IDX_W'(IDX_OVF))
                    st_d.regs[IDX_OVF][LCMP8_BIT] = wr_data_i[LCMP8_BIT];
            end else begin
                st_d.regs[wr_idx_i[SEL_W-1:0]] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.regs;

    assert_locked_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && prot && wr_idx_i < IDX_W'(IDX_OVF)) |=> $stable(st_q.regs));

    assert_ovf_locked_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && prot && wr_idx_i == IDX_W'(IDX_OVF)) |=>
        ({st_q.regs[IDX_OVF][7:5], st_q.regs[IDX_OVF][3:0]} ==
         $past({st_q.regs[IDX_OVF][7:5], st_q.regs[IDX_OVF][3:0]})));

    assert_lcmp8_writable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == IDX_W'(IDX_OVF)) |=>
        (st_q.regs[IDX_OVF][LCMP8_BIT] == $past(wr_data_i[LCMP8_BIT])));

    assert_oob_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i >= IDX_W'(NUM_REGS)) |=> $stable(st_q.regs));
endmodule

// File: rtl/crtc_vert_map.sv
module crtc_vert_map #(
    parameter int DATA_W = 8,
    localparam int VERT_W = DATA_W + 2
) (
    input  logic [DATA_W-1:0] ovf_i,
    input  logic [DATA_W-1:0] mscan_i,
    input  logic [DATA_W-1:0] vtot_lo_i,
    input  logic [DATA_W-1:0] vdend_lo_i,
    input  logic [DATA_W-1:0] vrstart_lo_i,
    input  logic [DATA_W-1:0] vbstart_lo_i,
    input  logic [DATA_W-1:0] lcmp_lo_i,
    output logic [VERT_W-1:0] vtotal_o,
    output logic [VERT_W-1:0] vdisp_end_o,
    output logic [VERT_W-1:0] vret_start_o,
    output logic [VERT_W-1:0] vblank_start_o,
    output logic [VERT_W-1:0] line_cmp_o
);
    always_comb begin
        vtotal_o       = {ovf_i[5],   ovf_i[0], vtot_lo_i};
        vdisp_end_o    = {ovf_i[6],   ovf_i[1], vdend_lo_i};
        vret_start_o   = {ovf_i[7],   ovf_i[2], vrstart_lo_i};
        vblank_start_o = {mscan_i[5], ovf_i[3], vbstart_lo_i};
        line_cmp_o     = {mscan_i[6], ovf_i[4], lcmp_lo_i};
    end
endmodule

// File: rtl/crtc_vint.sv
module crtc_vint
    import crtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vret_i,
    input  logic ack_i,
    input  logic mask_i,
    output logic irq_o
);
    vint_state_t st_d, st_q;
    logic        rise;

    assign rise = vret_i && !st_q.vret_prev;

    always_comb begin
        st_d           = st_q;
        st_d.vret_prev = vret_i;
        if (ack_i) st_d.pending = 1'b0;
        if (rise)  st_d.pending = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.pending && !mask_i;

    assert_edge_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vret_i && !st_q.vret_prev) |=> st_q.pending);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(vret_i && !st_q.vret_prev)) |=> !st_q.pending);

    assert_level_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pending && !ack_i && !(vret_i && !st_q.vret_prev)) |=> !st_q.pending);

    assert_mask_blocks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> !irq_o);
endmodule

// File: rtl/vga_crtc_regbank.sv
module vga_crtc_regbank
    import crtc_pkg::*;
#(
    parameter int NUM_REGS = 25,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 8,
    localparam int VERT_W  = DATA_W + 2,
    localparam int ADDR_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic [IDX_W-1:0]  idx_wdata,
    output logic [IDX_W-1:0]  idx_rdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              vret,
    output logic              irq,
    output logic [DATA_W-1:0] htotal,
    output logic [DATA_W-1:0] hdisp_end,
    output logic [DATA_W-1:0] hret_start,
    output logic [VERT_W-1:0] vtotal,
    output logic [VERT_W-1:0] vdisp_end,
    output logic [VERT_W-1:0] vret_start,
    output logic [VERT_W-1:0] vblank_start,
    output logic [VERT_W-1:0] line_cmp,
    output logic [3:0]        vret_end,
    output logic [4:0]        max_scan,
    output logic              dbl_scan,
    output logic [4:0]        preset_row,
    output logic [1:0]        byte_pan,
    output logic [4:0]        cur_start,
    output logic              cur_off,
    output logic [4:0]        cur_end,
    output logic [1:0]        cur_skew,
    output logic [ADDR_W-1:0] disp_start,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] row_offset
);
    logic [IDX_W-1:0]                idx;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic                            ack;

    crtc_index_port #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .we_i(idx_we), .wdata_i(idx_wdata), .idx_o(idx)
    );

    crtc_reg_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en_i(dat_we), .wr_idx_i(idx),
        .wr_data_i(dat_wdata), .regs_o(regs)
    );

    crtc_vert_map #(.DATA_W(DATA_W)) u_vmap (
        .ovf_i(regs[IDX_OVF]), .mscan_i(regs[IDX_MSCAN]),
        .vtot_lo_i(regs[IDX_VTOT]), .vdend_lo_i(regs[IDX_VDEND]),
        .vrstart_lo_i(regs[IDX_VRSTART]), .vbstart_lo_i(regs[IDX_VBSTART]),
        .lcmp_lo_i(regs[IDX_LCMP]),
        .vtotal_o(vtotal), .vdisp_end_o(vdisp_end), .vret_start_o(vret_start),
        .vblank_start_o(vblank_start), .line_cmp_o(line_cmp)
    );

    assign ack = dat_we && (idx == IDX_W'(IDX_VRCTL)) && !dat_wdata[VI_KEEP_BIT];

    crtc_vint u_vint (
        .clk(clk), .rst_n(rst_n), .vret_i(vret), .ack_i(ack),
        .mask_i(regs[IDX_VRCTL][VI_OFF_BIT]), .irq_o(irq)
    );

    assign idx_rdata  = idx;
    assign htotal     = regs[IDX_HTOT];
    assign hdisp_end  = regs[IDX_HDISP];
    assign hret_start = regs[IDX_HRET];
    assign vret_end   = regs[IDX_VRCTL][3:0];
    assign max_scan   = regs[IDX_MSCAN][4:0];
    assign dbl_scan   = regs[IDX_MSCAN][7];
    assign preset_row = regs[IDX_PRESET][4:0];
    assign byte_pan   = regs[IDX_PRESET][6:5];
    assign cur_start  = regs[IDX_CSTART][4:0];
    assign cur_off    = regs[IDX_CSTART][5];
    assign cur_end    = regs[IDX_CEND][4:0];
    assign cur_skew   = regs[IDX_CEND][6:5];
    assign disp_start = {regs[IDX_SADDR_H], regs[IDX_SADDR_L]};
    assign cur_addr   = {regs[IDX_CADDR_H], regs[IDX_CADDR_L]};
    assign row_offset = regs[IDX_ROWOFS];
endmodule

// File: tb/vga_crtc_regbank_tb_top.sv
module vga_crtc_regbank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idx_we = 1'b0, dat_we = 1'b0, vret = 1'b0;
    logic [7:0] idx_wdata = '0, dat_wdata = '0;
    logic [7:0] idx_rdata, htotal, hdisp_end, hret_start, row_offset;
    logic [9:0] vtotal, vdisp_end, vret_start, vblank_start, line_cmp;
    logic [3:0] vret_end;
    logic [4:0] max_scan, preset_row, cur_start, cur_end;
    logic dbl_scan, cur_off, irq;
    logic [1:0] byte_pan, cur_skew;
    logic [15:0] disp_start, cur_addr;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vga_crtc_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .idx_rdata(idx_rdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .vret(vret), .irq(irq), .htotal(htotal), .hdisp_end(hdisp_end),
        .hret_start(hret_start), .vtotal(vtotal), .vdisp_end(vdisp_end),
        .vret_start(vret_start), .vblank_start(vblank_start), .line_cmp(line_cmp),
        .vret_end(vret_end), .max_scan(max_scan), .dbl_scan(dbl_scan),
        .preset_row(preset_row), .byte_pan(byte_pan), .cur_start(cur_start),
        .cur_off(cur_off), .cur_end(cur_end), .cur_skew(cur_skew),
        .disp_start(disp_start), .cur_addr(cur_addr), .row_offset(row_offset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] i);
        @(negedge clk); idx_we = 1'b1; idx_wdata = i;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] d);
        set_idx(i);
        dat_we = 1'b1; dat_wdata = d;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 index", 32'(idx_rdata), 0);
        check("R11 irq", 32'(irq), 0);
        check("R11 vtotal", 32'(vtotal), 0);
        check("R11 disp_start", 32'(disp_start), 0);
    endtask

    task automatic t_index;
        set_idx(8'h13); check("R1 idx 13", 32'(idx_rdata), 32'h13);
        set_idx(8'hFF); check("R1 idx ff", 32'(idx_rdata), 32'hFF);
    endtask

    task automatic t_vert;
        wr(8'h06, 8'h0D); wr(8'h12, 8'h8F); wr(8'h10, 8'h9C);
        wr(8'h15, 8'h96); wr(8'h18, 8'hFF); wr(8'h09, 8'h6F);
        wr(8'h07, 8'hA5);
        check("R4 vtotal a", 32'(vtotal), 32'h30D);
        check("R4 vdisp a", 32'(vdisp_end), 32'h08F);
        check("R4 vret a", 32'(vret_start), 32'h39C);
        check("R5 vblank a", 32'(vblank_start), 32'h296);
        check("R5 lcmp a", 32'(line_cmp), 32'h2FF);
        wr(8'h07, 8'h5A);
        check("R4 vtotal b", 32'(vtotal), 32'h00D);
        check("R4 vdisp b", 32'(vdisp_end), 32'h38F);
        check("R4 vret b", 32'(vret_start), 32'h09C);
        check("R5 vblank b", 32'(vblank_start), 32'h396);
        check("R5 lcmp b", 32'(line_cmp), 32'h3FF);
    endtask

    task automatic t_protect;
        wr(8'h00, 8'h5F); check("R2 htotal open", 32'(htotal), 32'h5F);
        wr(8'h11, 8'h80);
        wr(8'h00, 8'h12); check("R2 htotal locked", 32'(htotal), 32'h5F);
        wr(8'h04, 8'h33); check("R2 hret locked", 32'(hret_start), 32'h00);
        wr(8'h07, 8'h00);
        check("R3 lcmp bit8 cleared", 32'(line_cmp), 32'h2FF);
        check("R2 vdisp kept", 32'(vdisp_end), 32'h38F);
        wr(8'h07, 8'hFF);
        check("R3 lcmp bit8 set", 32'(line_cmp), 32'h3FF);
        check("R2 vtotal kept", 32'(vtotal), 32'h00D);
        wr(8'h11, 8'h00);
        wr(8'h00, 8'h12); check("R2 htotal reopened", 32'(htotal), 32'h12);
    endtask

    task automatic t_addr;
        wr(8'h0C, 8'hAB); check("R6 start hi", 32'(disp_start), 32'hAB00);
        wr(8'h0D, 8'hCD); check("R6 start lo", 32'(disp_start), 32'hABCD);
        wr(8'h0C, 8'h12); check("R6 start hi again", 32'(disp_start), 32'h12CD);
        wr(8'h0F, 8'h34); check("R6 cursor lo", 32'(cur_addr), 32'h0034);
        wr(8'h0E, 8'h56); check("R6 cursor hi", 32'(cur_addr), 32'h5634);
    endtask

    task automatic t_cursor;
        wr(8'h0A, 8'h2E);
        check("R7 cursor off", 32'(cur_off), 1);
        check("R7 cursor start", 32'(cur_start), 32'h0E);
        wr(8'h0A, 8'h0E); check("R7 cursor on", 32'(cur_off), 0);
        wr(8'h0B, 8'h6F);
        check("R7 cursor end", 32'(cur_end), 32'h0F);
        check("R7 skew 3", 32'(cur_skew), 3);
        wr(8'h0B, 8'h2F); check("R7 skew 1", 32'(cur_skew), 1);
    endtask

    task automatic t_misc;
        wr(8'h08, 8'h45);
        check("R12 preset", 32'(preset_row), 32'h05);
        check("R12 pan", 32'(byte_pan), 2);
        wr(8'h09, 8'h83);
        check("R12 max scan", 32'(max_scan), 3);
        check("R12 dbl scan", 32'(dbl_scan), 1);
    endtask

    task automatic t_oob;
        wr(8'h19, 8'hFF);
        check("R1 idx 19", 32'(idx_rdata), 32'h19);
        wr(8'hFF, 8'hFF);
        check("R10 htotal", 32'(htotal), 32'h12);
        check("R10 disp_start", 32'(disp_start), 32'h12CD);
        check("R10 cur_addr", 32'(cur_addr), 32'h5634);
        check("R10 vtotal", 32'(vtotal), 32'h00D);
        check("R10 max_scan", 32'(max_scan), 3);
        check("R10 vret_end", 32'(vret_end), 0);
        check("R10 irq", 32'(irq), 0);
    endtask

    task automatic t_irq;
        @(negedge clk); vret = 1'b1;
        @(negedge clk); vret = 1'b0;
        check("R8 edge sets", 32'(irq), 1);
        wr(8'h11, 8'h10); check("R8 bit4 set keeps", 32'(irq), 1);
        wr(8'h11, 8'h30); check("R9 masked", 32'(irq), 0);
        wr(8'h11, 8'h10); check("R9 unmask keeps pending", 32'(irq), 1);
        wr(8'h11, 8'h00); check("R8 cleared", 32'(irq), 0);
        @(negedge clk); vret = 1'b1;
        @(negedge clk); check("R8 held edge", 32'(irq), 1);
        wr(8'h11, 8'h00);
        repeat (3) @(negedge clk);
        check("R8 level no retrigger", 32'(irq), 0);
        vret = 1'b0;
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = 8'h00; vret = 1'b1;
        @(negedge clk); dat_we = 1'b0; vret = 1'b0;
        check("R8 set wins", 32'(irq), 1);
        wr(8'h11, 8'h00); check("R8 final clear", 32'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_index();
        t_vert();
        t_protect();
        t_addr();
        t_cursor();
        t_misc();
        t_oob();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule